// File: doc/BRIEF.md
# Command/Response Buffer Controller

This block sits behind two host-visible registers, a status word and a byte-wide data FIFO window. It steers one command/response exchange at a time through five phases: idle, ready, reception, execution and completion. A single byte buffer holds the outgoing command and then the returning response, and one offset tracks the host's progress through it. The host writes command bytes until the length carried in the command header is reached, then issues a go request. The buffer is lent to an external execution engine through a start/done handshake, and the response is handed back byte by byte.

Arbitration between requesters is not part of the block. A single `host_owner` input says whether the current access comes from the requester that owns the interface; all other accesses are neutralised. Three one-cycle event pulses tell an interrupt controller when the block became ready, when a response arrived and when the status became valid.

Top module: `cmd_resp_buf`

## Requirements
- R1: After synchronous reset the block is idle with offset 0. The status word reads as family code in [27:26], burst count in [23:8], valid in [7], command-ready in [6], data-available in [4], expect in [3], self-test-done in [2], other bits 0. After reset all flags are clear and the burst count equals BUF_DEPTH.
- R2: A status write that requests command-ready (bit 6, with go bit 5 and retry bit 1 clear) in idle moves to ready. It sets only the command-ready flag and pulses `evt_cmd_ready`.
- R3: The first FIFO write in ready moves to reception and sets expect and valid. FIFO writes in idle, execution or completion store nothing and leave the offset unchanged.
- R4: Once the offset exceeds 5, the command length is the big-endian 32-bit value in buffer bytes 2..5. Expect stays set while that length exceeds the offset and clears once the offset reaches it.
- R5: A go request (bit 5 alone) is acted on only in reception with expect clear. It enters execution and pulses `eng_start` with `eng_len` equal to the bytes received. The engine port reaches the buffer only during execution.
- R6: `eng_done` in execution enters completion, clears the offset and sets valid and data-available. It pulses `evt_data_avail` together with `evt_sts_valid`.
- R7: FIFO reads in completion with data-available return response bytes little-endian and advance the offset. The read that takes the last byte leaves only valid set and pulses `evt_sts_valid`. Any byte lane with no response byte behind it reads 0xFF.
- R8: A retry request (bit 1 alone) in completion rewinds the read offset and sets valid and data-available again.
- R9: The burst count is the remaining response length while data-available is set, and the free buffer space otherwise. A 1-byte status read clamps it to 0xFF. Status reads return the word shifted right by 8 times the byte lane.
- R10: A command-ready request behaves as follows in the other phases. In ready it clears the offset. In reception it returns at once to ready with only command-ready set. In completion it goes to ready with only command-ready set. In execution it pulses `eng_cancel` and enters ready with only command-ready set when `eng_done` arrives.
- R11: A FIFO access never crosses a 4-byte boundary. Its byte count is min(size, 4 - lane), and lanes past that count read 0x00.
- R12: While `host_owner` is low, writes change nothing and reads return 0xFFFFFFFF.
- R13: `eng_selftest` with `eng_done` sets self-test-done, which survives every later flag change until reset. The family bits never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_owner | input | 1 | Current access comes from the owning requester |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = status register, 1 = data FIFO |
| acc_lane | input | 2 | Starting byte lane of the access |
| acc_size | input | 3 | Access size in bytes, 1 to 4 |
| acc_wdata | input | 32 | Write data, FIFO bytes packed from bit 0 |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| eng_start | output | 1 | Command handed to the engine |
| eng_len | output | $clog2(BUF_DEPTH)+1 | Command byte count |
| eng_cancel | output | 1 | Cancel request to the engine |
| eng_done | input | 1 | Engine finished |
| eng_resp_len | input | $clog2(BUF_DEPTH)+1 | Response byte count |
| eng_selftest | input | 1 | Self-test passed, sampled with eng_done |
| eng_addr | input | $clog2(BUF_DEPTH) | Engine buffer byte address |
| eng_we | input | 1 | Engine buffer write |
| eng_wdata | input | 8 | Engine write byte |
| eng_rdata | output | 8 | Engine read byte, one cycle latency |
| evt_cmd_ready | output | 1 | Command-ready event pulse |
| evt_data_avail | output | 1 | Data-available event pulse |
| evt_sts_valid | output | 1 | Status-valid event pulse |

## Verification
The per-cycle properties cover the following: each flag appears only in its own phase, the offset stays within the buffer, and an engine start is issued only on entry to execution from reception. They also check that a cancel only happens with an abort pending, that each event pulse matches the phase it announces, and that every read returns data one cycle later. The data path itself can only be shown by the directed scenarios. These include the big-endian header length ending reception, byte packing and boundary trimming, the 0xFF filler past the response, burst clamping, the retry rewind, and the deferred abort that completes only when the engine reports done.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_CMPL  = 3'd4
  } crb_state_e;

  // header length field occupies these byte positions (big-endian)
  localparam int HDR_FIRST = 2;
  localparam int HDR_LAST  = 5;
  localparam logic [7:0] NO_DATA = 8'hFF;
endpackage

// File: rtl/crb_bank_mem.sv
`timescale 1ns/1ps
// Four byte-wide single-port banks; byte address a lives in bank a[1:0].
module crb_bank_mem #(
  parameter int ROWS  = 256,
  parameter int ROW_W = 8
) (
  input  logic                  clk,
  input  logic [3:0]            en,
  input  logic [3:0]            we,
  input  logic [3:0][ROW_W-1:0] row,
  input  logic [3:0][7:0]       wdata,
  output logic [3:0][7:0]       q
);
  for (genvar b = 0; b < 4; b++) begin : g_bank
    logic [7:0] store [ROWS];
    always_ff @(posedge clk) begin
      if (en[b]) begin
        if (we[b]) store[row[b]] <= wdata[b];
        q[b] <= store[row[b]];
      end
    end
  end
endmodule

// File: rtl/crb_hdr_len.sv
`timescale 1ns/1ps
// Tracks the big-endian length field as command bytes stream in.
module crb_hdr_len #(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       n,
  input  logic [31:0]      wbytes,
  output logic [31:0]      hdr_next
);
  import crb_pkg::*;
  logic [31:0] hdr_q;

  always_comb begin
    hdr_next = hdr_q;
    for (int k = 0; k < 4; k++) begin
      for (int p = HDR_FIRST; p <= HDR_LAST; p++) begin
        if (wr_en && (3'(k) < n) && (off + OFF_W'(k) == OFF_W'(p)))
          hdr_next[8*(HDR_LAST-p) +: 8] = wbytes[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hdr_q <= '0;
    else     hdr_q <= hdr_next;
  end
endmodule

// File: rtl/crb_burst.sv
`timescale 1ns/1ps
module crb_burst #(
  parameter int BUF_DEPTH = 1024,
  parameter int OFF_W     = 11
) (
  input  logic             davail,
  input  logic             one_byte,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] resp_len,
  output logic [15:0]      burst
);
  logic [OFF_W-1:0] span;
  always_comb begin
    span = davail ? (resp_len - off) : (OFF_W'(BUF_DEPTH) - off);
    if (one_byte && span > OFF_W'(255)) burst = 16'd255;
    else                                burst = 16'(span);
  end
endmodule

// File: rtl/cmd_resp_buf.sv
`timescale 1ns/1ps
module cmd_resp_buf #(
  parameter int         BUF_DEPTH = 1024,
  parameter logic [1:0] FAMILY    = 2'b10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          host_owner,
  input  logic                          acc_valid,
  input  logic                          acc_write,
  input  logic                          acc_sel,
  input  logic [1:0]                    acc_lane,
  input  logic [2:0]                    acc_size,
  input  logic [31:0]                   acc_wdata,
  output logic                          rd_valid,
  output logic [31:0]                   rd_data,
  output logic                          eng_start,
  output logic [$clog2(BUF_DEPTH):0]    eng_len,
  output logic                          eng_cancel,
  input  logic                          eng_done,
  input  logic [$clog2(BUF_DEPTH):0]    eng_resp_len,
  input  logic                          eng_selftest,
  input  logic [$clog2(BUF_DEPTH)-1:0]  eng_addr,
  input  logic                          eng_we,
  input  logic [7:0]                    eng_wdata,
  output logic [7:0]                    eng_rdata,
  output logic                          evt_cmd_ready,
  output logic                          evt_data_avail,
  output logic                          evt_sts_valid
);
  import crb_pkg::*;

  localparam int ADDR_W = $clog2(BUF_DEPTH);
  localparam int OFF_W  = ADDR_W + 1;
  localparam int ROWS   = BUF_DEPTH / 4;
  localparam int ROW_W  = ADDR_W - 2;

  crb_state_e       state_q;
  logic [OFF_W-1:0] off_q, resp_len_q;
  logic             fl_valid, fl_cmdrdy, fl_davail, fl_expect, selftest_q, abort_q;

  // ---------------- access decode ----------------
  logic [2:0] room4, eff;
  assign room4 = 3'd4 - {1'b0, acc_lane};
  assign eff   = (acc_size > room4) ? room4 : acc_size;

  logic own_acc, wr_fifo, rd_fifo, wr_sts, rd_sts;
  assign own_acc = acc_valid && host_owner;
  assign wr_fifo = own_acc &&  acc_write &&  acc_sel;
  assign rd_fifo = own_acc && !acc_write &&  acc_sel;
  assign wr_sts  = own_acc &&  acc_write && !acc_sel;
  assign rd_sts  = own_acc && !acc_write && !acc_sel;

  // control bits sit in byte 0 of the status word
  logic b_rdy, b_go, b_retry;
  assign b_rdy   = (acc_lane == 2'd0) && acc_wdata[6];
  assign b_go    = (acc_lane == 2'd0) && acc_wdata[5];
  assign b_retry = (acc_lane == 2'd0) && acc_wdata[1];

  logic req_rdy, req_go, req_retry;
  assign req_rdy   = wr_sts &&  b_rdy && !b_go && !b_retry;
  assign req_go    = wr_sts && !b_rdy &&  b_go && !b_retry;
  assign req_retry = wr_sts && !b_rdy && !b_go &&  b_retry;

  logic in_exec, exec_done;
  assign in_exec   = (state_q == ST_EXEC);
  assign exec_done = in_exec && eng_done;

  // ---------------- command write path ----------------
  logic [OFF_W-1:0] eff_w, room, n_wr_w, new_off;
  logic             overflow, fifo_take;
  assign eff_w     = OFF_W'(eff);
  assign room      = OFF_W'(BUF_DEPTH) - off_q;
  assign overflow  = eff_w > room;
  assign n_wr_w    = overflow ? room : eff_w;
  assign new_off   = off_q + n_wr_w;
  assign fifo_take = wr_fifo && !exec_done &&
                     ((state_q == ST_READY) || (state_q == ST_RECV && fl_expect));

  logic [31:0] hdr_next;
  crb_hdr_len #(.OFF_W(OFF_W)) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fifo_take),
    .off      (off_q),
    .n        (3'(n_wr_w)),
    .wbytes   (acc_wdata),
    .hdr_next (hdr_next)
  );

  logic expect_next;
  always_comb begin
    if (overflow)                   expect_next = 1'b0;
    else if (new_off > OFF_W'(5))   expect_next = hdr_next > 32'(new_off);
    else                            expect_next = 1'b1;
  end

  // ---------------- response read path ----------------
  logic [OFF_W-1:0] remain, n_rd_w;
  logic             rd_avail, rd_last;
  assign remain   = resp_len_q - off_q;
  assign n_rd_w   = (eff_w > remain) ? remain : eff_w;
  assign rd_avail = rd_fifo && !exec_done && (state_q == ST_CMPL) && fl_davail;
  assign rd_last  = (off_q + n_rd_w) >= resp_len_q;

  // ---------------- buffer banks ----------------
  logic [3:0]            mem_en, mem_we;
  logic [3:0][ROW_W-1:0] mem_row;
  logic [3:0][7:0]       mem_wd, mem_q;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [1:0]       k_b;
    logic [OFF_W-1:0] a_b;
    logic             host_we;
    assign k_b       = 2'(b) - off_q[1:0];
    assign a_b       = off_q + OFF_W'(k_b);
    assign host_we   = fifo_take && (OFF_W'(k_b) < n_wr_w);
    assign mem_en[b] = in_exec ? (eng_addr[1:0] == 2'(b)) : (host_we || rd_fifo);
    assign mem_we[b] = in_exec ? (eng_we && eng_addr[1:0] == 2'(b)) : host_we;
    assign mem_row[b] = in_exec ? ROW_W'(eng_addr >> 2) : ROW_W'(a_b >> 2);
    assign mem_wd[b]  = in_exec ? eng_wdata : acc_wdata[{k_b, 3'b000} +: 8];
  end

  crb_bank_mem #(.ROWS(ROWS), .ROW_W(ROW_W)) u_mem (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .row   (mem_row),
    .wdata (mem_wd),
    .q     (mem_q)
  );

  logic [1:0] eng_lane_q;
  always_ff @(posedge clk) begin
    if (rst) eng_lane_q <= '0;
    else     eng_lane_q <= eng_addr[1:0];
  end
  assign eng_rdata = mem_q[eng_lane_q];

  // ---------------- status word ----------------
  logic [15:0] burst;
  crb_burst #(.BUF_DEPTH(BUF_DEPTH), .OFF_W(OFF_W)) u_burst (
    .davail   (fl_davail),
    .one_byte (acc_size == 3'd1),
    .off      (off_q),
    .resp_len (resp_len_q),
    .burst    (burst)
  );

  logic [31:0] sts_word;
  assign sts_word = {4'b0, FAMILY, 2'b0, burst, fl_valid, fl_cmdrdy, 1'b0,
                     fl_davail, fl_expect, selftest_q, 2'b0};

  // ---------------- read return ----------------
  logic [3:0]  used_v, mask_v, rd_used_q, rd_mask_q;
  logic [1:0]  rd_base_q;
  logic        rd_fifo_q;
  logic [31:0] rd_word_q;
  logic [31:0] fifo_word;

  for (genvar k = 0; k < 4; k++) begin : g_rd
    assign used_v[k] = 3'(k) < eff;
    assign mask_v[k] = rd_avail && (OFF_W'(k) < n_rd_w);
    assign fifo_word[8*k +: 8] = !rd_used_q[k] ? 8'h00 :
                                 rd_mask_q[k]  ? mem_q[rd_base_q + 2'(k)] : NO_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_fifo_q <= 1'b0;
      rd_word_q <= '0;
      rd_used_q <= '0;
      rd_mask_q <= '0;
      rd_base_q <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) begin
        rd_fifo_q <= rd_fifo;
        rd_base_q <= off_q[1:0];
        rd_used_q <= used_v;
        rd_mask_q <= mask_v;
        rd_word_q <= rd_sts ? (sts_word >> {acc_lane, 3'b000}) : 32'hFFFF_FFFF;
      end
    end
  end
  assign rd_data = rd_fifo_q ? fifo_word : rd_word_q;

  // ---------------- phase control ----------------
  always_ff @(posedge clk) begin
    eng_start      <= 1'b0;
    eng_cancel     <= 1'b0;
    evt_cmd_ready  <= 1'b0;
    evt_data_avail <= 1'b0;
    evt_sts_valid  <= 1'b0;
    if (rst) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      resp_len_q <= '0;
      fl_valid   <= 1'b0;
      fl_cmdrdy  <= 1'b0;
      fl_davail  <= 1'b0;
      fl_expect  <= 1'b0;
      selftest_q <= 1'b0;
      abort_q    <= 1'b0;
      eng_len    <= '0;
    end else if (exec_done) begin
      if (eng_selftest) selftest_q <= 1'b1;
      off_q     <= '0;
      abort_q   <= 1'b0;
      fl_expect <= 1'b0;
      if (abort_q) begin
        state_q       <= ST_READY;
        fl_cmdrdy     <= 1'b1;
        fl_valid      <= 1'b0;
        fl_davail     <= 1'b0;
        evt_cmd_ready <= 1'b1;
      end else begin
        state_q        <= ST_CMPL;
        fl_cmdrdy      <= 1'b0;
        fl_valid       <= 1'b1;
        fl_davail      <= 1'b1;
        resp_len_q     <= (eng_resp_len > OFF_W'(BUF_DEPTH)) ? OFF_W'(BUF_DEPTH) : eng_resp_len;
        evt_data_avail <= 1'b1;
        evt_sts_valid  <= 1'b1;
      end
    end else begin
      if (req_rdy) begin
        case (state_q)
          ST_READY: off_q <= '0;
          ST_EXEC: begin
            eng_cancel <= 1'b1;
            abort_q    <= 1'b1;
          end
          default: begin   // idle, reception, completion
            state_q       <= ST_READY;
            off_q         <= '0;
            fl_cmdrdy     <= 1'b1;
            fl_valid      <= 1'b0;
            fl_davail     <= 1'b0;
            fl_expect     <= 1'b0;
            evt_cmd_ready <= 1'b1;
          end
        endcase
      end else if (req_go && state_q == ST_RECV && !fl_expect) begin
        state_q   <= ST_EXEC;
        eng_start <= 1'b1;
        eng_len   <= off_q;
      end else if (req_retry && state_q == ST_CMPL) begin
        off_q     <= '0;
        fl_valid  <= 1'b1;
        fl_davail <= 1'b1;
        fl_cmdrdy <= 1'b0;
        fl_expect <= 1'b0;
      end

      if (fifo_take) begin
        state_q   <= ST_RECV;
        off_q     <= new_off;
        fl_valid  <= 1'b1;
        fl_cmdrdy <= 1'b0;
        fl_davail <= 1'b0;
        fl_expect <= expect_next;
      end

      if (rd_avail) begin
        off_q <= off_q + n_rd_w;
        if (rd_last) begin
          fl_davail     <= 1'b0;
          evt_sts_valid <= 1'b1;
        end
      end
    end
  end
endmodule

module cmd_resp_buf_chk #(
  parameter int BUF_DEPTH = 1024
) (
  input logic                       clk,
  input logic                       rst,
  input crb_pkg::crb_state_e        state,
  input logic [$clog2(BUF_DEPTH):0] off,
  input logic                       fl_expect,
  input logic                       fl_davail,
  input logic                       fl_cmdrdy,
  input logic                       abort,
  input logic                       eng_start,
  input logic                       eng_cancel,
  input logic                       evt_cmd_ready,
  input logic                       evt_data_avail,
  input logic                       evt_sts_valid,
  input logic                       acc_valid,
  input logic                       acc_write,
  input logic                       rd_valid
);
  import crb_pkg::*;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && off == '0));

  a_r4_offset_bound: assert property (@(posedge clk) disable iff (rst)
    off <= ($clog2(BUF_DEPTH)+1)'(BUF_DEPTH));

  a_r3_expect_only_recv: assert property (@(posedge clk) disable iff (rst)
    fl_expect |-> state == ST_RECV);

  a_r5_start_from_recv: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (state == ST_EXEC && $past(state) == ST_RECV));

  a_r6_davail_only_cmpl: assert property (@(posedge clk) disable iff (rst)
    fl_davail |-> state == ST_CMPL);

  a_r6_events_paired: assert property (@(posedge clk) disable iff (rst)
    evt_data_avail |-> (evt_sts_valid && state == ST_CMPL));

  a_r2_cmdrdy_event: assert property (@(posedge clk) disable iff (rst)
    evt_cmd_ready |-> (state == ST_READY && fl_cmdrdy));

  a_r10_cancel_pending: assert property (@(posedge clk) disable iff (rst)
    eng_cancel |-> (state == ST_EXEC && abort));

  a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);
endmodule

bind cmd_resp_buf cmd_resp_buf_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .state          (state_q),
  .off            (off_q),
  .fl_expect      (fl_expect),
  .fl_davail      (fl_davail),
  .fl_cmdrdy      (fl_cmdrdy),
  .abort          (abort_q),
  .eng_start      (eng_start),
  .eng_cancel     (eng_cancel),
  .evt_cmd_ready  (evt_cmd_ready),
  .evt_data_avail (evt_data_avail),
  .evt_sts_valid  (evt_sts_valid),
  .acc_valid      (acc_valid),
  .acc_write      (acc_write),
  .rd_valid       (rd_valid)
);

// File: tb/cmd_resp_buf_tb.sv
`timescale 1ns/1ps
module cmd_resp_buf_tb;
  localparam int         DEPTH = 1024;
  localparam int         AW    = $clog2(DEPTH);
  localparam logic [1:0] FAM   = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic host_owner = 1'b1;
  logic acc_valid = 0, acc_write = 0, acc_sel = 0;
  logic [1:0] acc_lane = 0;
  logic [2:0] acc_size = 3'd4;
  logic [31:0] acc_wdata = 0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic eng_start, eng_cancel;
  logic [AW:0] eng_len;
  logic eng_done = 0, eng_selftest = 0, eng_we = 0;
  logic [AW:0] eng_resp_len = 0;
  logic [AW-1:0] eng_addr = 0;
  logic [7:0] eng_wdata = 0, eng_rdata;
  logic evt_cmd_ready, evt_data_avail, evt_sts_valid;

  always #4 clk = ~clk;

  cmd_resp_buf #(.BUF_DEPTH(DEPTH), .FAMILY(FAM)) u_dut (
    .clk(clk), .rst(rst), .host_owner(host_owner),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_lane(acc_lane), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_start(eng_start), .eng_len(eng_len), .eng_cancel(eng_cancel),
    .eng_done(eng_done), .eng_resp_len(eng_resp_len), .eng_selftest(eng_selftest),
    .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
    .evt_cmd_ready(evt_cmd_ready), .evt_data_avail(evt_data_avail),
    .evt_sts_valid(evt_sts_valid)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] rv;
  logic e_cr, e_da, e_sv, e_st, e_cn;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] sw(input logic [7:0] fl, input int burst);
    return {4'b0, FAM, 2'b0, 16'(burst), fl};
  endfunction

  task automatic acc(input logic wr, input logic sel, input logic [1:0] lane,
                     input logic [2:0] size, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_sel = sel; acc_lane = lane;
    acc_size = size; acc_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    rv = rd_data; e_cr = evt_cmd_ready; e_da = evt_data_avail; e_sv = evt_sts_valid;
    e_st = eng_start; e_cn = eng_cancel;
  endtask

  task automatic sts(input logic [2:0] size, input logic [1:0] lane);
    acc(1'b0, 1'b0, lane, size, 32'h0);
  endtask

  task automatic eng_finish(input int rlen, input logic st);
    @(negedge clk);
    eng_done = 1; eng_resp_len = (AW+1)'(rlen); eng_selftest = st;
    @(posedge clk);
    @(negedge clk);
    eng_done = 0; eng_selftest = 0;
    e_cr = evt_cmd_ready; e_da = evt_data_avail; e_sv = evt_sts_valid;
  endtask

  task automatic send_full_cmd();
    acc(1, 1, 2'd0, 3'd4, 32'h0000_0180);
    acc(1, 1, 2'd0, 3'd4, 32'h0000_0A00);
    acc(1, 1, 2'd0, 3'd2, 32'h0000_4401);
  endtask

  task automatic t_reset();
    sts(3'd4, 2'd0);
    chk("R1 reset status", rv, sw(8'h00, DEPTH));
    acc(0, 1, 2'd0, 3'd4, 0);
    chk("R7 fifo read in idle", rv, 32'hFFFF_FFFF);
    acc(1, 1, 2'd0, 3'd4, 32'h1234_5678);
    sts(3'd4, 2'd0);
    chk("R3 idle write dropped", rv, sw(8'h00, DEPTH));
  endtask

  task automatic t_ready();
    acc(1, 0, 2'd0, 3'd1, 32'h40);
    chk("R2 evt_cmd_ready", {31'b0, e_cr}, 1);
    sts(3'd4, 2'd0);
    chk("R2 ready status", rv, sw(8'h40, DEPTH));
    sts(3'd1, 2'd1);
    chk("R9 1-byte clamp lane1", rv, sw(8'h40, 255) >> 8);
  endtask

  task automatic t_command();
    acc(1, 1, 2'd0, 3'd4, 32'h0000_0180);
    sts(3'd4, 2'd0);
    chk("R3 reception expect+valid", rv, sw(8'h88, DEPTH - 4));
    acc(1, 1, 2'd0, 3'd4, 32'h0000_0A00);
    sts(3'd4, 2'd0);
    chk("R4 expect held len>off", rv, sw(8'h88, DEPTH - 8));
    acc(1, 0, 2'd0, 3'd1, 32'h20);
    chk("R5 go ignored while expect", {31'b0, e_st}, 0);
    acc(1, 1, 2'd0, 3'd2, 32'h0000_4401);
    sts(3'd4, 2'd0);
    chk("R4 expect cleared at len", rv, sw(8'h80, DEPTH - 10));
    acc(1, 0, 2'd0, 3'd1, 32'h20);
    chk("R5 eng_start", {31'b0, e_st}, 1);
    chk("R5 eng_len", 32'(eng_len), 10);
    acc(1, 1, 2'd0, 3'd4, 32'hDEAD_BEEF);
    sts(3'd4, 2'd0);
    chk("R3 exec write dropped", rv, sw(8'h80, DEPTH - 10));
    @(negedge clk); eng_addr = 0;
    @(posedge clk); @(negedge clk);
    chk("R5 engine reads byte0", 32'(eng_rdata), 32'h80);
  endtask

  task automatic t_response();
    logic [7:0] resp [10] = '{8'hC4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0A,
                              8'h11, 8'h22, 8'h33, 8'h44};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); eng_we = 1; eng_addr = AW'(i); eng_wdata = resp[i];
      @(posedge clk);
    end
    @(negedge clk); eng_we = 0;
    eng_finish(10, 1'b0);
    chk("R6 event pair", {30'b0, e_da, e_sv}, 3);
    sts(3'd4, 2'd0);
    chk("R6/R9 completion status", rv, sw(8'h90, 10));
    acc(0, 1, 2'd0, 3'd4, 0);
    chk("R7 little-endian read", rv, 32'h0000_00C4);
    acc(0, 1, 2'd2, 3'd4, 0);
    chk("R11 trimmed read", rv, 32'h0000_0A00);
    sts(3'd4, 2'd0);
    chk("R9 burst remaining", rv, sw(8'h90, 4));
    acc(1, 1, 2'd0, 3'd4, 32'h5555_5555);
    acc(1, 0, 2'd0, 3'd1, 32'h02);
    sts(3'd4, 2'd0);
    chk("R8 retry status", rv, sw(8'h90, 10));
    acc(0, 1, 2'd0, 3'd4, 0);
    chk("R8 reread byte0 / R3 cmpl write dropped", rv, 32'h0000_00C4);
    acc(0, 1, 2'd0, 3'd4, 0);
    chk("R7 bytes 4..7", rv, 32'h2211_0A00);
    acc(0, 1, 2'd0, 3'd4, 0);
    chk("R7 tail filler", rv, 32'hFFFF_4433);
    chk("R7 last-byte evt_sts_valid", {31'b0, e_sv}, 1);
    sts(3'd4, 2'd0);
    chk("R7 only valid left", rv, sw(8'h80, DEPTH - 10));
    acc(0, 1, 2'd0, 3'd4, 0);
    chk("R7 read past end", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_owner();
    host_owner = 0;
    acc(1, 0, 2'd0, 3'd1, 32'h40);
    sts(3'd4, 2'd0);
    chk("R12 non-owner read", rv, 32'hFFFF_FFFF);
    host_owner = 1;
    sts(3'd4, 2'd0);
    chk("R12 non-owner write ignored", rv, sw(8'h80, DEPTH - 10));
  endtask

  task automatic t_aborts();
    acc(1, 0, 2'd0, 3'd1, 32'h40);
    chk("R10 completion shortcut evt", {31'b0, e_cr}, 1);
    sts(3'd4, 2'd0);
    chk("R10 completion to ready", rv, sw(8'h40, DEPTH));
    acc(1, 1, 2'd0, 3'd4, 32'h0000_0180);
    acc(1, 0, 2'd0, 3'd1, 32'h40);
    sts(3'd4, 2'd0);
    chk("R10 reception abort", rv, sw(8'h40, DEPTH));
    acc(1, 0, 2'd0, 3'd1, 32'h40);
    sts(3'd4, 2'd0);
    chk("R10 ready keeps offset 0", rv, sw(8'h40, DEPTH));
    send_full_cmd();
    acc(1, 0, 2'd0, 3'd1, 32'h20);
    acc(1, 0, 2'd0, 3'd1, 32'h40);
    chk("R10 exec cancel pulse", {31'b0, e_cn}, 1);
    sts(3'd4, 2'd0);
    chk("R10 still executing", rv, sw(8'h80, DEPTH - 10));
    eng_finish(10, 1'b1);
    chk("R10 abort done evt", {30'b0, e_cr, e_da}, 2);
    sts(3'd4, 2'd0);
    chk("R13 selftest kept after abort", rv, sw(8'h44, DEPTH));
    acc(1, 1, 2'd0, 3'd4, 32'h0000_0180);
    sts(3'd4, 2'd0);
    chk("R13 selftest sticky in reception", rv, sw(8'h8C, DEPTH - 4));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_ready();
    t_command();
    t_response();
    t_owner();
    t_aborts();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule